// File: doc/BRIEF.md
# Single-Operand File Register Execute Unit

This block is the execute stage for the one-operand register instructions of a small accumulator-style controller. Each issued instruction selects one of four operations: zero a file register, zero the working register, invert every bit of a file register operand, or subtract one from it. The operand arrives as 8-bit read data already fetched from the 7-bit file address that travels with the instruction.

For the invert and subtract operations a destination bit steers the result: a 0 sends it to the working register, a 1 sends it back to the file register it came from. The block raises exactly one of two write enables, presents the result and the file address for the write-back, and keeps the zero flag up to date. All outputs are registered and due one clock after the instruction is issued.

Top module: `fru_unary_alu`

## Requirements
- R1: While reset is high at a rising clock edge, both write enables, the result and the zero flag are cleared to 0 and the write-back address is 0.
- R2: Operation code 0 (clear file) yields result 00h, asserts the file write enable, leaves the working-register enable low and sets the zero flag, whatever the destination bit.
- R3: Operation code 1 (clear working register) yields result 00h, asserts the working-register write enable, leaves the file enable low and sets the zero flag, whatever the destination bit.
- R4: Operation code 2 (invert) yields the bitwise complement of the operand.
- R5: Operation code 3 (subtract one) yields the operand minus one modulo 256, so 00h becomes FFh.
- R6: For codes 2 and 3 a destination bit of 0 asserts only the working-register enable and a destination bit of 1 asserts only the file enable.
- R7: For codes 2 and 3 the zero flag becomes 1 exactly when the result is 00h.
- R8: Every issued operation asserts exactly one of the two write enables, and the write-back address equals the file address that was issued.
- R9: A cycle without an issued instruction deasserts both enables and leaves the zero flag unchanged.
- R10: All results, enables, flag and address appear on the outputs one clock edge after the instruction is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| op_i | input | 2 | Operation code: 0 clear file, 1 clear working register, 2 invert, 3 subtract one |
| faddr_i | input | 7 | File register address of the instruction |
| dest_i | input | 1 | Destination: 0 working register, 1 file register |
| fdata_i | input | 8 | Operand read from the addressed file register |
| w_we_o | output | 1 | Write enable for the working register |
| f_we_o | output | 1 | Write enable for the file register |
| waddr_o | output | 7 | File address for the write-back |
| result_o | output | 8 | Operation result |
| zero_o | output | 1 | Zero flag |

## Verification
Every output of this block is due exactly one rising edge after the instruction is sampled, and the zero flag must additionally hold its value through idle cycles. The bench drives an instruction on a falling edge, lets one rising edge pass, and compares all outputs on the following falling edge, so each check lands on the single cycle in which that instruction's result is visible. The sweep covers every operation, both destination bits and all 256 operand values, with idle cycles inserted to confirm the flag is held and the enables drop.

// File: rtl/fru_pkg.sv
package fru_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;
    localparam int OP_W   = 2;

    typedef enum logic [OP_W-1:0] {
        OP_CLR_FILE = 2'd0,
        OP_CLR_WORK = 2'd1,
        OP_INVERT   = 2'd2,
        OP_DEC      = 2'd3
    } fru_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              zero;
    } fru_calc_t;

    typedef struct packed {
        logic to_work;
        logic to_file;
    } fru_route_t;

    function automatic logic is_all_zero(input logic [DATA_W-1:0] v);
        return (v == '0);
    endfunction

    function automatic logic op_honours_dest(input fru_op_e op);
        return (op == OP_INVERT) || (op == OP_DEC);
    endfunction

endpackage

// File: rtl/fru_compute.sv
module fru_compute
    import fru_pkg::*;
(
    input  fru_op_e                op,
    input  logic [DATA_W-1:0]      operand,
    output fru_calc_t              calc
);

    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] value;

    always_comb begin
        unique case (op)
            OP_CLR_FILE: value = '0;
            OP_CLR_WORK: value = '0;
            OP_INVERT:   value = ~operand;
            OP_DEC:      value = operand - ONE;
            default:     value = '0;
        endcase
    end

    always_comb begin
        calc.value = value;
        calc.zero  = is_all_zero(value);
    end

endmodule

// File: rtl/fru_route.sv
module fru_route
    import fru_pkg::*;
(
    input  logic       issue,
    input  fru_op_e    op,
    input  logic       dest,
    output fru_route_t route
);

    always_comb begin
        route = '0;
        if (issue) begin
            if (op_honours_dest(op)) begin
                route.to_work = ~dest;
                route.to_file = dest;
            end else if (op == OP_CLR_WORK) begin
                route.to_work = 1'b1;
            end else begin
                route.to_file = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fru_unary_alu.sv
module fru_unary_alu
    import fru_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                issue_i,
    input  logic [OP_W-1:0]     op_i,
    input  logic [ADDR_W-1:0]   faddr_i,
    input  logic                dest_i,
    input  logic [DATA_W-1:0]   fdata_i,
    output logic                w_we_o,
    output logic                f_we_o,
    output logic [ADDR_W-1:0]   waddr_o,
    output logic [DATA_W-1:0]   result_o,
    output logic                zero_o
);

    fru_op_e    op;
    fru_calc_t  calc;
    fru_route_t route;

    assign op = fru_op_e'(op_i);

    fru_compute u_compute (
        .op      (op),
        .operand (fdata_i),
        .calc    (calc)
    );

    fru_route u_route (
        .issue (issue_i),
        .op    (op),
        .dest  (dest_i),
        .route (route)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            w_we_o   <= 1'b0;
            f_we_o   <= 1'b0;
            waddr_o  <= '0;
            result_o <= '0;
            zero_o   <= 1'b0;
        end else begin
            w_we_o <= route.to_work;
            f_we_o <= route.to_file;
            if (issue_i) begin
                waddr_o  <= faddr_i;
                result_o <= calc.value;
                zero_o   <= calc.zero;
            end
        end
    end

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
        issue_i |=> ($countones({w_we_o, f_we_o}) == 1)); // R8
    AST_ADDR_CARRIED: assert property (@(posedge clk) disable iff (rst)
        issue_i |=> (waddr_o == $past(faddr_i))); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !issue_i |=> (!w_we_o && !f_we_o)); // R9
    AST_IDLE_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
        (!issue_i && !$past(rst)) |=> $stable(zero_o)); // R9
    AST_CLR_FILE: assert property (@(posedge clk) disable iff (rst)
        (issue_i && op_i == 2'd0) |=> (f_we_o && result_o == '0 && zero_o)); // R2
    AST_CLR_WORK: assert property (@(posedge clk) disable iff (rst)
        (issue_i && op_i == 2'd1) |=> (w_we_o && result_o == '0 && zero_o)); // R3
    AST_INVERT: assert property (@(posedge clk) disable iff (rst)
        (issue_i && op_i == 2'd2) |=> (result_o == ~$past(fdata_i))); // R4
    AST_DEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (issue_i && op_i == 2'd3) |=> (result_o == $past(fdata_i) - 8'd1)); // R5
    AST_DEST_STEER: assert property (@(posedge clk) disable iff (rst)
        (issue_i && op_i[1]) |=> (f_we_o == $past(dest_i))); // R6
    AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (rst)
        issue_i |=> (zero_o == (result_o == '0))); // R7

endmodule

// File: tb/fru_unary_alu_bench.sv
`timescale 1ns/1ps
module fru_unary_alu_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       issue_i;
    logic [1:0] op_i;
    logic [6:0] faddr_i;
    logic       dest_i;
    logic [7:0] fdata_i;
    logic       w_we_o, f_we_o, zero_o;
    logic [6:0] waddr_o;
    logic [7:0] result_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    fru_unary_alu u_fru_unary_alu (
        .clk(clk), .rst(rst), .issue_i(issue_i), .op_i(op_i),
        .faddr_i(faddr_i), .dest_i(dest_i), .fdata_i(fdata_i),
        .w_we_o(w_we_o), .f_we_o(f_we_o), .waddr_o(waddr_o),
        .result_o(result_o), .zero_o(zero_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue one instruction on a falling edge, check on the next falling edge (R10).
    task automatic run_op(input logic [1:0] op, input logic dest,
                          input logic [6:0] addr, input logic [7:0] data);
        logic [7:0] exp_res;
        logic       exp_w, exp_f;
        string      rq;
        @(negedge clk);
        issue_i = 1'b1; op_i = op; dest_i = dest; faddr_i = addr; fdata_i = data;
        case (op)
            2'd0: begin exp_res = 8'h00; exp_w = 0; exp_f = 1; rq = "R2"; end
            2'd1: begin exp_res = 8'h00; exp_w = 1; exp_f = 0; rq = "R3"; end
            2'd2: begin exp_res = 8'hFF ^ data; exp_w = !dest; exp_f = dest; rq = "R4"; end
            default: begin exp_res = (data + 8'd255) % 256; exp_w = !dest; exp_f = dest; rq = "R5"; end
        endcase
        @(negedge clk);
        issue_i = 1'b0;
        check(rq, "result (R10 one-cycle)", result_o, exp_res);
        check(op[1] ? "R6" : rq, "w_we", w_we_o, exp_w);
        check(op[1] ? "R6" : rq, "f_we", f_we_o, exp_f);
        check(op[1] ? "R7" : rq, "zero", zero_o, exp_res == 8'h00);
        check("R8", "one enable", 32'(w_we_o) + 32'(f_we_o), 1);
        check("R8", "waddr", waddr_o, addr);
    endtask

    // Idle cycle with disturbed inputs: enables drop and flag holds.
    task automatic idle_check(input logic held_zero);
        @(negedge clk);
        issue_i = 1'b0; op_i = 2'd0; fdata_i = 8'h5A; dest_i = 1'b1;
        @(negedge clk);
        check("R9", "idle w_we", w_we_o, 0);
        check("R9", "idle f_we", f_we_o, 0);
        check("R9", "idle zero held", zero_o, held_zero);
    endtask

    initial begin
        rst = 1'b1; issue_i = 1'b0; op_i = 2'd0; faddr_i = '0; dest_i = 1'b0; fdata_i = '0;
        @(negedge clk); @(negedge clk);
        check("R1", "reset w_we", w_we_o, 0);
        check("R1", "reset f_we", f_we_o, 0);
        check("R1", "reset result", result_o, 0);
        check("R1", "reset zero", zero_o, 0);
        check("R1", "reset waddr", waddr_o, 0);
        rst = 1'b0;

        for (int op = 0; op < 4; op++) begin
            for (int d = 0; d < 2; d++) begin
                for (int v = 0; v < 256; v++) begin
                    run_op(2'(op), 1'(d), 7'((v * 37 + op) % 128), 8'(v));
                end
            end
        end

        // R5 wrap and R7 zero via subtract one, then R9 holds each flag value
        run_op(2'd3, 1'b1, 7'd127, 8'h00);
        idle_check(1'b0);
        run_op(2'd3, 1'b0, 7'd0, 8'h01);
        idle_check(1'b1);
        run_op(2'd2, 1'b1, 7'd64, 8'hFF);
        idle_check(1'b1);
        run_op(2'd2, 1'b0, 7'd1, 8'h00);
        idle_check(1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule